// File: doc/BRIEF.md
# Backplane Bus Master Cycle Controller

This block lets an 8-bit 68000-family processor act as a master on an asynchronous, STEbus-style backplane. The processor's own bus cycle is watched. When the cycle falls in the backplane window, the block wins the backplane, drives the backplane strobes in a fixed order, waits for the slave's reply and ends the processor cycle. A good reply ends the cycle with DTACK. A transfer error or a local timeout ends it with a bus error.

All backplane replies and the bus grant come from another timing domain, so each passes through a two-flop synchronizer. The analog settling delay between turning on the bus drivers and asserting the address strobe is a count of clock cycles. A strap input selects permanent-master mode. In that mode the block is the only master, so it never raises a request and never waits for a grant.

The state machine has eight states:
- `S_IDLE`: waits for a claimed cycle. It goes to `S_REQ`, or to `S_SETTLE` in permanent-master mode.
- `S_REQ`: holds the bus request. It goes to `S_SETTLE` once the synchronized grant is seen.
- `S_SETTLE`: turns the drivers on and counts the settling cycles. It then goes to `S_ADDR`.
- `S_ADDR`: asserts the address strobe, then goes to `S_DATA`.
- `S_DATA`: asserts the data strobe and waits for an acknowledge, an error or the timeout. It then goes to `S_DROP_DS`.
- `S_DROP_DS`: releases the data strobe and presents the termination. It goes to `S_DROP_AS`.
- `S_DROP_AS`: releases the address strobe, then goes to `S_WAIT_AS`.
- `S_WAIT_AS`: turns the drivers off and holds the termination until the processor address strobe goes high. It then goes to `S_IDLE`.

Top module: `bkp_master_ctl`

## Requirements
- R1: A cycle is claimed only when `cpu_as_n` and `cpu_ds_n` are both low and `cpu_a21` is high. Any other input combination leaves `bp_drv_en_n`, `bp_busrq_n`, `cpu_dtack_n` and `cpu_berr_n` high.
- R2: In a claimed cycle, `bp_drv_en_n` goes low first. `bp_adrstb_n` goes low `SETTLE_CYC` cycles later, and `bp_datstb_n` goes low one cycle after that.
- R3: On termination, `bp_datstb_n` goes high first. `bp_adrstb_n` goes high one cycle later, and `bp_drv_en_n` goes high one cycle after that.
- R4: A low `bp_datack_n` ends the cycle with `cpu_dtack_n` low and `cpu_berr_n` high. A low `bp_trferr_n` ends it with `cpu_berr_n` low, and so does an acknowledge and an error arriving together. Either output goes low in the cycle the data strobe is released.
- R5: `bp_cm` follows `cpu_a20`. A value of 0 selects an I/O access and 1 selects a memory access.
- R6: A timeout counter is cleared while the drivers are off. It counts while they are on. If no reply arrives, the data strobe is released with `cpu_berr_n` low, `TIMEOUT_CYC` cycles after `bp_drv_en_n` fell.
- R7: Outside permanent-master mode, a claimed cycle drives `bp_busrq_n` low. The drivers stay off until `bp_grant_n` is seen low, and `bp_drv_en_n` falls three cycles after the grant arrives.
- R8: With `perm_master` high, `bp_busrq_n` stays high and `bp_drv_en_n` falls in the cycle after the claim.
- R9: The termination output stays low for as long as `cpu_as_n` is low, with the drivers off. It goes high one cycle after `cpu_as_n` is raised. No new cycle starts before that.
- R10: `bp_datack_n`, `bp_trferr_n` and `bp_grant_n` pass through two-flop synchronizers. A reply arriving during the data phase releases the data strobe three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_ds_n | input | 1 | Processor data strobe, active low |
| cpu_a21 | input | 1 | Address bit 21; high selects the backplane |
| cpu_a20 | input | 1 | Address bit 20; gives the command bit |
| bp_datack_n | input | 1 | Backplane data acknowledge, active low, asynchronous |
| bp_trferr_n | input | 1 | Backplane transfer error, active low, asynchronous |
| bp_grant_n | input | 1 | Selected bus grant, active low, asynchronous |
| perm_master | input | 1 | Strap for permanent-master mode |
| bp_drv_en_n | output | 1 | Backplane driver enable, active low |
| bp_adrstb_n | output | 1 | Backplane address strobe, active low |
| bp_datstb_n | output | 1 | Backplane data strobe, active low |
| bp_cm | output | 1 | Command bit: 0 for I/O, 1 for memory |
| bp_busrq_n | output | 1 | Bus request, active low |
| cpu_dtack_n | output | 1 | Data acknowledge to the processor, active low |
| cpu_berr_n | output | 1 | Bus error to the processor, active low |

## Verification
The timeout path is the hardest case to reach from the ports. It fires only when a claimed, granted cycle sits in the data phase for the whole timeout window with neither backplane reply line active. The bench reaches it with vector entries that never answer the data strobe, in both master modes. It then measures the distance from driver enable to data-strobe release against `TIMEOUT_CYC`. A second hard case is a grant withheld for many cycles, and a third is an address strobe held long after the termination. Both are driven as directed tests, which check that the drivers stay off and that the termination does not drop.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_SETTLE,
        S_ADDR,
        S_DATA,
        S_DROP_DS,
        S_DROP_AS,
        S_WAIT_AS
    } bkp_state_e;

endpackage

// File: rtl/bkp_sync2.sv
module bkp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Reset to all ones: every synchronized line is active low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/bkp_timeout.sv
module bkp_timeout #(
    parameter int TIMEOUT_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_active,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!drv_active) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = drv_active && (cnt == LAST);

    // R6: the count always starts from zero when the drivers come on.
    assert_cnt_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_active) |-> (cnt == '0));

endmodule

// File: rtl/bkp_seq.sv
module bkp_seq
    import bkp_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_as_n,
    input  logic cpu_ds_n,
    input  logic cpu_a21,
    input  logic perm_master,
    input  logic ack_s_n,
    input  logic err_s_n,
    input  logic grant_s_n,
    input  logic tmo_expired,
    output logic drv_active,
    output logic drv_en_n,
    output logic adrstb_n,
    output logic datstb_n,
    output logic busrq_n,
    output logic dtack_n,
    output logic berr_n
);
    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    bkp_state_e state;
    bkp_state_e nxt;
    logic [SW-1:0] settle_cnt;
    logic err_flag;
    logic claim;
    logic reply;

    assign claim = !cpu_as_n && !cpu_ds_n && cpu_a21;
    assign reply = !ack_s_n || !err_s_n || tmo_expired;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (claim) nxt = perm_master ? S_SETTLE : S_REQ;
            S_REQ:     if (!grant_s_n) nxt = S_SETTLE;
            S_SETTLE:  if (settle_cnt == SETTLE_LAST) nxt = S_ADDR;
            S_ADDR:    nxt = S_DATA;
            S_DATA:    if (reply) nxt = S_DROP_DS;
            S_DROP_DS: nxt = S_DROP_AS;
            S_DROP_AS: nxt = S_WAIT_AS;
            S_WAIT_AS: if (cpu_as_n) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register, settle counter and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            settle_cnt <= '0;
            err_flag   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_SETTLE) settle_cnt <= settle_cnt + 1'b1;
            else                   settle_cnt <= '0;
            // An error or a timeout wins over an acknowledge.
            if (state == S_DATA && reply)
                err_flag <= !err_s_n || tmo_expired;
        end
    end

    // Output decode
    always_comb begin
        drv_en_n = 1'b1;
        adrstb_n = 1'b1;
        datstb_n = 1'b1;
        busrq_n  = 1'b1;
        dtack_n  = 1'b1;
        berr_n   = 1'b1;
        unique case (state)
            S_IDLE: ;
            S_REQ:  busrq_n = perm_master;
            S_SETTLE: begin
                busrq_n  = perm_master;
                drv_en_n = 1'b0;
            end
            S_ADDR: begin
                busrq_n  = perm_master;
                drv_en_n = 1'b0;
                adrstb_n = 1'b0;
            end
            S_DATA: begin
                busrq_n  = perm_master;
                drv_en_n = 1'b0;
                adrstb_n = 1'b0;
                datstb_n = 1'b0;
            end
            S_DROP_DS: begin
                busrq_n  = perm_master;
                drv_en_n = 1'b0;
                adrstb_n = 1'b0;
                dtack_n  = err_flag;
                berr_n   = !err_flag;
            end
            S_DROP_AS: begin
                busrq_n  = perm_master;
                drv_en_n = 1'b0;
                dtack_n  = err_flag;
                berr_n   = !err_flag;
            end
            S_WAIT_AS: begin
                dtack_n = err_flag;
                berr_n  = !err_flag;
            end
            default: ;
        endcase
    end

    assign drv_active = !drv_en_n;

    // R2: the data strobe is only ever active under the address strobe,
    // and the address strobe only with the drivers enabled.
    assert_ds_under_as_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !datstb_n |-> !adrstb_n);
    assert_as_under_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adrstb_n |-> !drv_en_n);
    // R3: release order data strobe, address strobe, drivers.
    assert_as_follows_ds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(datstb_n) |=> $rose(adrstb_n));
    assert_en_follows_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adrstb_n) |=> $rose(drv_en_n));
    // R4: never both terminations.
    assert_term_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !berr_n));
    // R6: an expiry during the data phase ends the cycle.
    assert_tmo_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && tmo_expired) |=> (state == S_DROP_DS));
    // R9: the termination holds while the address strobe is low.
    assert_dtack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !cpu_as_n) |=> !dtack_n);
    assert_berr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_n && !cpu_as_n) |=> !berr_n);

endmodule

// File: rtl/bkp_master_ctl.sv
module bkp_master_ctl #(
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_as_n,
    input  logic cpu_ds_n,
    input  logic cpu_a21,
    input  logic cpu_a20,
    input  logic bp_datack_n,
    input  logic bp_trferr_n,
    input  logic bp_grant_n,
    input  logic perm_master,
    output logic bp_drv_en_n,
    output logic bp_adrstb_n,
    output logic bp_datstb_n,
    output logic bp_cm,
    output logic bp_busrq_n,
    output logic cpu_dtack_n,
    output logic cpu_berr_n
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] async_in;
    logic [NSYNC-1:0] sync_out;
    logic drv_active;
    logic tmo_expired;

    assign async_in = {bp_grant_n, bp_trferr_n, bp_datack_n};

    bkp_sync2 #(.W(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (async_in),
        .q_sync  (sync_out)
    );

    bkp_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .drv_active (drv_active),
        .expired    (tmo_expired)
    );

    bkp_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_as_n    (cpu_as_n),
        .cpu_ds_n    (cpu_ds_n),
        .cpu_a21     (cpu_a21),
        .perm_master (perm_master),
        .ack_s_n     (sync_out[0]),
        .err_s_n     (sync_out[1]),
        .grant_s_n   (sync_out[2]),
        .tmo_expired (tmo_expired),
        .drv_active  (drv_active),
        .drv_en_n    (bp_drv_en_n),
        .adrstb_n    (bp_adrstb_n),
        .datstb_n    (bp_datstb_n),
        .busrq_n     (bp_busrq_n),
        .dtack_n     (cpu_dtack_n),
        .berr_n      (cpu_berr_n)
    );

    // R5: the command bit comes straight from address bit 20.
    assign bp_cm = cpu_a20;

endmodule

// File: tb/bkp_master_ctl_test.sv
module bkp_master_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2;
    localparam int TMO        = 128;

    // resp: 0 ack, 1 error, 2 both, 3 none
    typedef struct packed {
        logic       perm;
        logic       a21;
        logic       a20;
        logic [1:0] resp;
        logic       claim;
        logic       berr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{perm: 1'b1, a21: 1'b1, a20: 1'b0, resp: 2'd0, claim: 1'b1, berr: 1'b0},
        '{perm: 1'b1, a21: 1'b1, a20: 1'b1, resp: 2'd1, claim: 1'b1, berr: 1'b1},
        '{perm: 1'b0, a21: 1'b1, a20: 1'b0, resp: 2'd0, claim: 1'b1, berr: 1'b0},
        '{perm: 1'b0, a21: 1'b1, a20: 1'b1, resp: 2'd2, claim: 1'b1, berr: 1'b1},
        '{perm: 1'b1, a21: 1'b1, a20: 1'b1, resp: 2'd3, claim: 1'b1, berr: 1'b1},
        '{perm: 1'b0, a21: 1'b1, a20: 1'b0, resp: 2'd3, claim: 1'b1, berr: 1'b1},
        '{perm: 1'b1, a21: 1'b0, a20: 1'b1, resp: 2'd0, claim: 1'b0, berr: 1'b0},
        '{perm: 1'b0, a21: 1'b0, a20: 1'b0, resp: 2'd0, claim: 1'b0, berr: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_as_n = 1'b1, cpu_ds_n = 1'b1, cpu_a21 = 1'b0, cpu_a20 = 1'b0;
    logic bp_datack_n = 1'b1, bp_trferr_n = 1'b1, bp_grant_n = 1'b1;
    logic perm_master = 1'b0;
    logic bp_drv_en_n, bp_adrstb_n, bp_datstb_n, bp_cm, bp_busrq_n;
    logic cpu_dtack_n, cpu_berr_n;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkp_master_ctl #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_as_n(cpu_as_n), .cpu_ds_n(cpu_ds_n),
        .cpu_a21(cpu_a21), .cpu_a20(cpu_a20),
        .bp_datack_n(bp_datack_n), .bp_trferr_n(bp_trferr_n),
        .bp_grant_n(bp_grant_n), .perm_master(perm_master),
        .bp_drv_en_n(bp_drv_en_n), .bp_adrstb_n(bp_adrstb_n),
        .bp_datstb_n(bp_datstb_n), .bp_cm(bp_cm), .bp_busrq_n(bp_busrq_n),
        .cpu_dtack_n(cpu_dtack_n), .cpu_berr_n(cpu_berr_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic release_all();
        cpu_as_n = 1'b1; cpu_ds_n = 1'b1;
        bp_datack_n = 1'b1; bp_trferr_n = 1'b1; bp_grant_n = 1'b1;
    endtask

    // All times are negedge indices counted from the negedge that drives the claim.
    task automatic run_vec(input vec_t v);
        int t_en = -1, t_as = -1, t_ds = -1, t_dsr = -1, t_asr = -1, t_enr = -1;
        int t_gr = -1, t_resp = -1;
        bit rq_seen = 1'b0, quiet = 1'b1, cm_ok = 1'b1;
        logic dt, be;
        @(negedge clk);
        perm_master = v.perm;
        cpu_a21 = v.a21; cpu_a20 = v.a20;
        cpu_as_n = 1'b0; cpu_ds_n = 1'b0;
        if (!v.claim) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (!bp_drv_en_n || !bp_busrq_n || !cpu_dtack_n || !cpu_berr_n) quiet = 1'b0;
                if (bp_cm !== v.a20) cm_ok = 1'b0;
            end
            check(quiet, "R1 unclaimed cycle stays quiet", quiet, 1);
            check(cm_ok, "R5 cm follows a20", bp_cm, v.a20);
            release_all();
            @(negedge clk);
            return;
        end
        for (int t = 1; t < 400 && t_enr < 0; t++) begin
            @(negedge clk);
            if (!bp_busrq_n) rq_seen = 1'b1;
            if (bp_cm !== v.a20) cm_ok = 1'b0;
            if (t_en < 0 && !bp_drv_en_n) t_en = t;
            if (t_as < 0 && !bp_adrstb_n) t_as = t;
            if (t_ds < 0 && !bp_datstb_n) t_ds = t;
            if (t_ds >= 0 && t_dsr < 0 && bp_datstb_n) begin
                t_dsr = t; dt = cpu_dtack_n; be = cpu_berr_n;
            end
            if (t_as >= 0 && t_asr < 0 && bp_adrstb_n) t_asr = t;
            if (t_en >= 0 && t_enr < 0 && bp_drv_en_n) t_enr = t;
            if (!v.perm && !bp_busrq_n && t_gr < 0) begin
                bp_grant_n = 1'b0; t_gr = t;
            end
            if (t_ds == t && v.resp != 2'd3) begin
                t_resp = t;
                bp_datack_n = (v.resp == 2'd1);
                bp_trferr_n = (v.resp == 2'd0);
            end
        end
        check(t_as - t_en == SETTLE, "R2 enable to address strobe", t_as - t_en, SETTLE);
        check(t_ds - t_as == 1, "R2 address to data strobe", t_ds - t_as, 1);
        check(t_asr - t_dsr == 1 && t_enr - t_asr == 1, "R3 release order",
              t_enr - t_dsr, 2);
        if (v.berr) check(dt === 1'b1 && be === 1'b0, "R4 ends with bus error", be, 0);
        else        check(dt === 1'b0 && be === 1'b1, "R4 ends with dtack", dt, 0);
        check(cm_ok, "R5 cm follows a20", bp_cm, v.a20);
        if (v.resp == 2'd3)
            check(t_dsr - t_en == TMO, "R6 timeout window", t_dsr - t_en, TMO);
        else
            check(t_dsr - t_resp == 3, "R10 reply synchronizer latency", t_dsr - t_resp, 3);
        if (v.perm) begin
            check(!rq_seen, "R8 no request in permanent mode", rq_seen, 0);
            check(t_en == 1, "R8 enable right after claim", t_en, 1);
        end else begin
            check(rq_seen && t_en - t_gr == 3, "R7 enable three cycles after grant",
                  t_en - t_gr, 3);
        end
        release_all();
        @(negedge clk);
        check(cpu_dtack_n && cpu_berr_n, "R9 termination drops after AS high",
              {cpu_dtack_n, cpu_berr_n}, 3);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit ok;
        repeat (3) @(negedge clk);
        check(bp_drv_en_n && bp_adrstb_n && bp_datstb_n && bp_busrq_n &&
              cpu_dtack_n && cpu_berr_n, "R1 reset state idle", bp_drv_en_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R1: strobe without data strobe is not claimed
        perm_master = 1'b1; cpu_a21 = 1'b1; cpu_as_n = 1'b0; cpu_ds_n = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!bp_drv_en_n || !cpu_dtack_n || !cpu_berr_n) ok = 1'b0;
        end
        check(ok, "R1 address strobe alone ignored", bp_drv_en_n, 1);
        release_all();
        @(negedge clk);

        // R7: withheld grant keeps the drivers off
        perm_master = 1'b0; cpu_a21 = 1'b1; cpu_a20 = 1'b1;
        cpu_as_n = 1'b0; cpu_ds_n = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k > 0 && (bp_busrq_n || !bp_drv_en_n)) ok = 1'b0;
        end
        check(ok, "R7 drivers off until grant", bp_drv_en_n, 1);
        bp_grant_n = 1'b0;
        n = 0;
        while (bp_datstb_n && n < 30) begin @(negedge clk); n++; end
        bp_datack_n = 1'b0;
        n = 0;
        while (!bp_drv_en_n && n < 30) begin @(negedge clk); n++; end

        // R9: hold AS low after termination; dtack stays, no new cycle
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (cpu_dtack_n || !bp_drv_en_n) ok = 1'b0;
        end
        check(ok, "R9 dtack held while AS low", cpu_dtack_n, 0);
        release_all();
        @(negedge clk);
        check(cpu_dtack_n, "R9 dtack released after AS high", cpu_dtack_n, 1);
        check(bp_busrq_n && bp_drv_en_n, "R7 request dropped after cycle", bp_busrq_n, 1);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule